// File: doc/BRIEF.md
# Hart Debug Handshake Tracker

This block keeps the debug-side view of a small array of harts. Harts running debug firmware report their progress with memory-mapped writes to three locations. A write to the halted location carries the hart id and marks that hart as halted. A write to the going location accepts a pending go order. A write to the resuming location carries the hart id and marks that hart as leaving debug. The debugger side supplies several inputs: a selection mask, the index of the single hart that abstract commands target, one-cycle pulses for resume request, command start, halt-on-reset set and clear, and have-reset acknowledge. It also supplies each hart's raw reset status and the halt-group request.

From these the block maintains per-hart halted and resume-request state, a single go register, halt-on-reset mask and interrupt bits, and have-reset bits. It publishes a flag word that the harts poll. Bit 2h is hart h's go flag and bit 2h+1 is its resume flag. Each hart also gets a halt interrupt.

Each hart slot runs a four-state machine: SL_RUN (neither halted nor resume pending), SL_HALT (halted), SL_RUN_RQ (resume pending, not halted) and SL_HALT_RQ (halted with resume pending). A resuming hit moves any state to SL_RUN. From SL_RUN, a halt hit together with a resume hit goes to SL_HALT_RQ, a halt hit alone goes to SL_HALT, and a resume hit alone goes to SL_RUN_RQ. SL_HALT moves to SL_HALT_RQ on a resume hit. SL_RUN_RQ moves to SL_HALT_RQ on a halt hit. SL_HALT_RQ holds until a resuming hit. The go machine has two states. GO_IDLE moves to GO_ARMED on command start. GO_ARMED moves to GO_IDLE on a going write, even if a start arrives in the same cycle.

Top module: `dbg_hart_tracker`

## Requirements
- R1: A halted write whose id names hart h (id below NUM_HARTS) makes halted[h] read 1 from the next cycle.
- R2: Halted and resuming writes whose id is NUM_HARTS or larger change no state.
- R3: A resume request sets the resume flag (flags bit 2h+1) of every hart whose hart_sel bit is 1, from the next cycle, until that hart writes resuming.
- R4: A resuming write naming hart h clears halted[h] and flags bit 2h+1 on the next cycle, and wins over a same-cycle halted write or resume request for that hart.
- R5: A command start arms the go register. While it is armed, flags bit 2*sel_hart is 1 and follows sel_hart in the same cycle. A going write disarms it, including when a start comes in that same cycle. At most one go flag is ever set.
- R6: set_hr sets and clr_hr clears the halt-on-reset mask of selected harts, and clear wins when both arrive together. A hart whose mask is set and whose synchronized reset is seen gets a halt-on-reset interrupt. That interrupt drops one cycle after the hart's halted bit is 1.
- R7: hart_in_reset passes through three flip-flops. have_reset[h] is set from the fourth edge after the input is sampled high and holds. An acknowledge with hart_sel[h] clears it, unless synchronized reset is still seen.
- R8: halt_irq[h] is the OR of hg_halt_req[h] and the hart's halt-on-reset interrupt.
- R9: One cycle with dm_active low clears all held state: slots, masks, interrupts, have-reset bits, the go register and the synchronizers.
- R10: After reset, flags, halted, have_reset and halt_irq are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dm_active | input | 1 | Debug logic enable; low clears state |
| halted_wr | input | 1 | Write strobe to the halted location |
| halted_id | input | ID_W | Hart id carried by the halted write |
| going_wr | input | 1 | Write strobe to the going location |
| resuming_wr | input | 1 | Write strobe to the resuming location |
| resuming_id | input | ID_W | Hart id carried by the resuming write |
| hart_sel | input | NUM_HARTS | Mask of selected harts |
| sel_hart | input | SEL_W | Index of the hart targeted by commands |
| resume_req | input | 1 | Resume request pulse |
| go_start | input | 1 | Abstract command start pulse |
| set_hr | input | 1 | Set halt-on-reset for selected harts |
| clr_hr | input | 1 | Clear halt-on-reset for selected harts |
| ack_have_reset | input | 1 | Acknowledge have-reset for selected harts |
| hart_in_reset | input | NUM_HARTS | Raw per-hart reset status |
| hg_halt_req | input | NUM_HARTS | Per-hart halt-group request |
| flags | output | 2*NUM_HARTS | Per-hart go (even bit) and resume (odd bit) flags |
| halted | output | NUM_HARTS | Per-hart halted status |
| have_reset | output | NUM_HARTS | Per-hart have-reset status |
| halt_irq | output | NUM_HARTS | Per-hart halt interrupt |

## Verification
The collisions of interest are a resuming write landing on the same edge as a resume request or a halted write for the same hart, and a go start landing on the same edge as a going write. Directed cycles drive these pairs together and expect the clearing action to win, except for a start arriving while the go register is idle. A clear of halt-on-reset in the same access as a set, and a have-reset acknowledge while the synchronized reset is still high, are also forced. The outcome is judged at the ports against the stated priority. A behavioural model also compares every output on every cycle while a pseudo-random phase overlaps all inputs freely.

// File: rtl/dbg_trk_pkg.sv
package dbg_trk_pkg;

    // Per-hart debug slot: bit 0 halted, bit 1 resume pending.
    typedef enum logic [1:0] {
        SL_RUN     = 2'b00,
        SL_HALT    = 2'b01,
        SL_RUN_RQ  = 2'b10,
        SL_HALT_RQ = 2'b11
    } slot_state_e;

    typedef enum logic {
        GO_IDLE  = 1'b0,
        GO_ARMED = 1'b1
    } go_state_e;

    localparam int SYNC_STAGES = 3;

endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else if (clear) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign sync_out = pipe_q[STAGES-1];

endmodule

// File: rtl/dbg_go_ctrl.sv
module dbg_go_ctrl
    import dbg_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dm_active,
    input  logic go_start,
    input  logic going_wr,
    output logic go_armed
);

    go_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GO_IDLE:  if (go_start) state_d = GO_ARMED;
            GO_ARMED: if (going_wr) state_d = GO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GO_IDLE;
        end else if (!dm_active) begin
            state_q <= GO_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        go_armed = (state_q == GO_ARMED);
    end

endmodule

// File: rtl/dbg_hart_slot.sv
module dbg_hart_slot
    import dbg_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dm_active,
    input  logic halt_hit,
    input  logic resume_hit,
    input  logic resuming_hit,
    input  logic hr_set_hit,
    input  logic hr_clr_hit,
    input  logic ack_hit,
    input  logic rst_seen,
    output logic halted_o,
    output logic resreq_o,
    output logic hr_irq_o,
    output logic have_reset_o
);

    slot_state_e state_q, state_d;
    logic        hr_mask_q, hr_mask_d;
    logic        hr_irq_q, hr_irq_d;
    logic        have_q, have_d;

    // Slot transitions; a resuming write dominates everything else.
    always_comb begin
        state_d = state_q;
        if (resuming_hit) begin
            state_d = SL_RUN;
        end else begin
            unique case (state_q)
                SL_RUN: begin
                    if (halt_hit && resume_hit) state_d = SL_HALT_RQ;
                    else if (halt_hit)          state_d = SL_HALT;
                    else if (resume_hit)        state_d = SL_RUN_RQ;
                end
                SL_HALT:    if (resume_hit) state_d = SL_HALT_RQ;
                SL_RUN_RQ:  if (halt_hit)   state_d = SL_HALT_RQ;
                SL_HALT_RQ: state_d = SL_HALT_RQ;
            endcase
        end
    end

    // Reset-related bits: clear dominates set for the mask, set dominates ack.
    always_comb begin
        hr_mask_d = hr_mask_q;
        if (hr_clr_hit)      hr_mask_d = 1'b0;
        else if (hr_set_hit) hr_mask_d = 1'b1;
        hr_irq_d = (hr_irq_q && !halted_o) || (rst_seen && hr_mask_q);
        have_d   = rst_seen || (have_q && !ack_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= SL_RUN;
            hr_mask_q <= 1'b0;
            hr_irq_q  <= 1'b0;
            have_q    <= 1'b0;
        end else if (!dm_active) begin
            state_q   <= SL_RUN;
            hr_mask_q <= 1'b0;
            hr_irq_q  <= 1'b0;
            have_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            hr_mask_q <= hr_mask_d;
            hr_irq_q  <= hr_irq_d;
            have_q    <= have_d;
        end
    end

    always_comb begin
        halted_o     = (state_q == SL_HALT) || (state_q == SL_HALT_RQ);
        resreq_o     = (state_q == SL_RUN_RQ) || (state_q == SL_HALT_RQ);
        hr_irq_o     = hr_irq_q;
        have_reset_o = have_q;
    end

endmodule

// File: rtl/dbg_hart_tracker.sv
module dbg_hart_tracker
    import dbg_trk_pkg::*;
#(
    parameter  int NUM_HARTS = 4,
    parameter  int ID_W      = 4,
    localparam int SEL_W     = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dm_active,
    input  logic                   halted_wr,
    input  logic [ID_W-1:0]        halted_id,
    input  logic                   going_wr,
    input  logic                   resuming_wr,
    input  logic [ID_W-1:0]        resuming_id,
    input  logic [NUM_HARTS-1:0]   hart_sel,
    input  logic [SEL_W-1:0]       sel_hart,
    input  logic                   resume_req,
    input  logic                   go_start,
    input  logic                   set_hr,
    input  logic                   clr_hr,
    input  logic                   ack_have_reset,
    input  logic [NUM_HARTS-1:0]   hart_in_reset,
    input  logic [NUM_HARTS-1:0]   hg_halt_req,
    output logic [2*NUM_HARTS-1:0] flags,
    output logic [NUM_HARTS-1:0]   halted,
    output logic [NUM_HARTS-1:0]   have_reset,
    output logic [NUM_HARTS-1:0]   halt_irq
);

    logic [NUM_HARTS-1:0] rst_seen;
    logic [NUM_HARTS-1:0] resreq;
    logic [NUM_HARTS-1:0] hr_irq;
    logic                 go_armed;

    dbg_rst_sync #(
        .WIDTH  (NUM_HARTS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!dm_active),
        .async_in (hart_in_reset),
        .sync_out (rst_seen)
    );

    dbg_go_ctrl u_go (
        .clk       (clk),
        .rst_n     (rst_n),
        .dm_active (dm_active),
        .go_start  (go_start),
        .going_wr  (going_wr),
        .go_armed  (go_armed)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
        logic halt_hit, resuming_hit;

        // Ids at or above NUM_HARTS never match any slot.
        assign halt_hit     = halted_wr   && (halted_id   == ID_W'(h));
        assign resuming_hit = resuming_wr && (resuming_id == ID_W'(h));

        dbg_hart_slot u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .dm_active    (dm_active),
            .halt_hit     (halt_hit),
            .resume_hit   (resume_req && hart_sel[h]),
            .resuming_hit (resuming_hit),
            .hr_set_hit   (set_hr && hart_sel[h]),
            .hr_clr_hit   (clr_hr && hart_sel[h]),
            .ack_hit      (ack_have_reset && hart_sel[h]),
            .rst_seen     (rst_seen[h]),
            .halted_o     (halted[h]),
            .resreq_o     (resreq[h]),
            .hr_irq_o     (hr_irq[h]),
            .have_reset_o (have_reset[h])
        );

        assign flags[2*h]   = go_armed && (sel_hart == SEL_W'(h));
        assign flags[2*h+1] = resreq[h];
        assign halt_irq[h]  = hg_halt_req[h] || hr_irq[h];
    end

endmodule

// File: rtl/dbg_hart_tracker_chk.sv
module dbg_hart_tracker_chk #(
    parameter  int NUM_HARTS = 4,
    parameter  int ID_W      = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   dm_active,
    input logic                   halted_wr,
    input logic [ID_W-1:0]        halted_id,
    input logic                   going_wr,
    input logic                   resuming_wr,
    input logic [ID_W-1:0]        resuming_id,
    input logic [NUM_HARTS-1:0]   hart_sel,
    input logic                   resume_req,
    input logic                   go_start,
    input logic [NUM_HARTS-1:0]   hg_halt_req,
    input logic [2*NUM_HARTS-1:0] flags,
    input logic [NUM_HARTS-1:0]   halted,
    input logic [NUM_HARTS-1:0]   have_reset,
    input logic [NUM_HARTS-1:0]   halt_irq
);

    logic [NUM_HARTS-1:0] go_bits;

    always_comb begin
        for (int h = 0; h < NUM_HARTS; h++) go_bits[h] = flags[2*h];
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_h
        p_halted_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (dm_active && halted_wr && halted_id == ID_W'(h)
             && !(resuming_wr && resuming_id == ID_W'(h))) |=> halted[h]);

        p_resume_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (dm_active && resume_req && hart_sel[h]
             && !(resuming_wr && resuming_id == ID_W'(h))) |=> flags[2*h+1]);

        p_resuming_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (resuming_wr && resuming_id == ID_W'(h)) |=> (!halted[h] && !flags[2*h+1]));
    end

    p_go_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go_bits));

    p_going_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (going_wr && !go_start) |=> (go_bits == '0));

    p_hg_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hg_halt_req & ~halt_irq) == '0));

    p_inactive_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dm_active |=> (halted == '0 && have_reset == '0 && flags == '0));

endmodule

bind dbg_hart_tracker dbg_hart_tracker_chk #(
    .NUM_HARTS (NUM_HARTS),
    .ID_W      (ID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dm_active   (dm_active),
    .halted_wr   (halted_wr),
    .halted_id   (halted_id),
    .going_wr    (going_wr),
    .resuming_wr (resuming_wr),
    .resuming_id (resuming_id),
    .hart_sel    (hart_sel),
    .resume_req  (resume_req),
    .go_start    (go_start),
    .hg_halt_req (hg_halt_req),
    .flags       (flags),
    .halted      (halted),
    .have_reset  (have_reset),
    .halt_irq    (halt_irq)
);

// File: tb/dbg_hart_tracker_test.sv
module dbg_hart_tracker_test;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dm_active = 1'b0;
    logic         halted_wr = 1'b0;
    logic [3:0]   halted_id = '0;
    logic         going_wr = 1'b0;
    logic         resuming_wr = 1'b0;
    logic [3:0]   resuming_id = '0;
    logic [N-1:0] hart_sel = '0;
    logic [1:0]   sel_hart = '0;
    logic         resume_req = 1'b0;
    logic         go_start = 1'b0;
    logic         set_hr = 1'b0;
    logic         clr_hr = 1'b0;
    logic         ack_have_reset = 1'b0;
    logic [N-1:0] hart_in_reset = '0;
    logic [N-1:0] hg_halt_req = '0;
    logic [2*N-1:0] flags;
    logic [N-1:0] halted, have_reset, halt_irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dbg_hart_tracker #(.NUM_HARTS(N), .ID_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .dm_active(dm_active),
        .halted_wr(halted_wr), .halted_id(halted_id), .going_wr(going_wr),
        .resuming_wr(resuming_wr), .resuming_id(resuming_id),
        .hart_sel(hart_sel), .sel_hart(sel_hart), .resume_req(resume_req),
        .go_start(go_start), .set_hr(set_hr), .clr_hr(clr_hr),
        .ack_have_reset(ack_have_reset), .hart_in_reset(hart_in_reset),
        .hg_halt_req(hg_halt_req), .flags(flags), .halted(halted),
        .have_reset(have_reset), .halt_irq(halt_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model.
    logic [N-1:0] m_halted = '0, m_req = '0, m_mask = '0, m_hr = '0, m_have = '0;
    logic         m_go = 1'b0;
    logic [N-1:0] m_pipe[$] = '{4'b0, 4'b0, 4'b0};

    always @(posedge clk) begin
        if (!rst_n || !dm_active) begin
            m_halted = '0; m_req = '0; m_mask = '0; m_hr = '0; m_have = '0;
            m_go = 1'b0;
            m_pipe = '{4'b0, 4'b0, 4'b0};
        end else begin
            logic [N-1:0] rs, o_halted, o_mask, o_hr;
            rs = m_pipe.pop_back();
            m_pipe.push_front(hart_in_reset);
            o_halted = m_halted; o_mask = m_mask; o_hr = m_hr;
            for (int h = 0; h < N; h++) begin
                bit hw, rw;
                hw = halted_wr && (int'(halted_id) == h);
                rw = resuming_wr && (int'(resuming_id) == h);
                m_halted[h] = (o_halted[h] | hw) & !rw;
                m_req[h]    = (m_req[h] | (resume_req & hart_sel[h])) & !rw;
                if (clr_hr && hart_sel[h])      m_mask[h] = 1'b0;
                else if (set_hr && hart_sel[h]) m_mask[h] = 1'b1;
                m_hr[h]   = (o_hr[h] & !o_halted[h]) | (rs[h] & o_mask[h]);
                m_have[h] = rs[h] | (m_have[h] & !(ack_have_reset & hart_sel[h]));
            end
            m_go = m_go ? !going_wr : go_start;
        end
    end

    // Per-cycle comparison, a quarter period after the active edge.
    always @(posedge clk) begin
        logic [2*N-1:0] e_flags;
        #5;
        for (int h = 0; h < N; h++) begin
            e_flags[2*h]   = m_go && (int'(sel_hart) == h);
            e_flags[2*h+1] = m_req[h];
        end
        chk("R1 halted vector", 32'(halted), 32'(m_halted));
        chk("R3/R5 flag word", 32'(flags), 32'(e_flags));
        chk("R7 have_reset vector", 32'(have_reset), 32'(m_have));
        chk("R6/R8 halt_irq vector", 32'(halt_irq), 32'(hg_halt_req | m_hr));
    end

    task automatic tick();
        @(posedge clk);
        #8;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        ticks(3);
        // R10: reset state
        chk("R10 flags at reset", 32'(flags), 32'h0);
        chk("R10 halted at reset", 32'(halted), 32'h0);
        chk("R10 have_reset at reset", 32'(have_reset), 32'h0);
        chk("R10 halt_irq at reset", 32'(halt_irq), 32'h0);
        rst_n = 1'b1; dm_active = 1'b1;
        tick();

        // R1: halted writes
        halted_wr = 1'b1; halted_id = 4'd0; tick();
        halted_id = 4'd2; tick();
        chk("R1 halted after ids 0,2", 32'(halted), 32'h5);
        // R2: out-of-range halted id
        halted_id = 4'd5; tick();
        halted_wr = 1'b0; tick();
        chk("R2 halted id 5 ignored", 32'(halted), 32'h5);

        // R3: resume request to harts 0 and 2
        hart_sel = 4'b0101; resume_req = 1'b1; tick();
        resume_req = 1'b0;
        chk("R3 resume flags", 32'(flags), 32'h22);
        // R4: resuming hart 0
        resuming_wr = 1'b1; resuming_id = 4'd0; tick();
        chk("R4 halted after resuming 0", 32'(halted), 32'h4);
        chk("R4 flags after resuming 0", 32'(flags), 32'h20);
        // R4: resuming, halted write and resume request on hart 2 together
        resuming_id = 4'd2; halted_wr = 1'b1; halted_id = 4'd2;
        hart_sel = 4'b0100; resume_req = 1'b1; tick();
        resuming_wr = 1'b0; halted_wr = 1'b0; resume_req = 1'b0;
        chk("R4 collision halted", 32'(halted), 32'h0);
        chk("R4 collision flags", 32'(flags), 32'h0);
        // R2: out-of-range resuming id
        halted_wr = 1'b1; halted_id = 4'd3; tick();
        halted_wr = 1'b0; resuming_wr = 1'b1; resuming_id = 4'd7; tick();
        chk("R2 resuming id 7 ignored", 32'(halted), 32'h8);
        resuming_id = 4'd3; tick();
        resuming_wr = 1'b0; hart_sel = '0;

        // R5: go flag
        sel_hart = 2'd1; go_start = 1'b1; tick();
        go_start = 1'b0;
        chk("R5 go flag hart 1", 32'(flags), 32'h04);
        sel_hart = 2'd3; #1;
        chk("R5 go flag follows sel_hart", 32'(flags), 32'h40);
        going_wr = 1'b1; tick();
        chk("R5 going clears", 32'(flags), 32'h0);
        go_start = 1'b1; tick();
        chk("R5 start+going while idle arms", 32'(flags), 32'h40);
        tick();
        chk("R5 start+going while armed disarms", 32'(flags), 32'h0);
        go_start = 1'b0; going_wr = 1'b0;

        // R6 / R7: halt on reset for hart 0
        hart_sel = 4'b0011; set_hr = 1'b1; tick();
        set_hr = 1'b0; hart_sel = '0;
        hart_in_reset = 4'b0001; ticks(3);
        chk("R7 have_reset not yet", 32'(have_reset), 32'h0);
        tick();
        chk("R7 have_reset after sync", 32'(have_reset), 32'h1);
        chk("R6 halt-on-reset irq", 32'(halt_irq), 32'h1);
        hart_in_reset = '0; ticks(4);
        halted_wr = 1'b1; halted_id = 4'd0; tick();
        halted_wr = 1'b0;
        chk("R6 irq held on halt edge", 32'(halt_irq), 32'h1);
        tick();
        chk("R6 irq dropped after halt", 32'(halt_irq), 32'h0);
        hart_sel = 4'b0001; ack_have_reset = 1'b1; tick();
        ack_have_reset = 1'b0;
        chk("R7 ack clears have_reset", 32'(have_reset), 32'h0);
        resuming_wr = 1'b1; resuming_id = 4'd0; tick();
        resuming_wr = 1'b0;
        // R6: set and clear together -> cleared
        hart_sel = 4'b0011; set_hr = 1'b1; clr_hr = 1'b1; tick();
        set_hr = 1'b0; clr_hr = 1'b0;
        hart_in_reset = 4'b0011; ticks(6);
        chk("R6 clear wins, no irq", 32'(halt_irq), 32'h0);
        chk("R7 have_reset harts 0,1", 32'(have_reset), 32'h3);
        ack_have_reset = 1'b1; tick();
        ack_have_reset = 1'b0;
        chk("R7 ack while in reset ignored", 32'(have_reset), 32'h3);
        hart_in_reset = '0; ticks(4);
        ack_have_reset = 1'b1; tick();
        ack_have_reset = 1'b0; hart_sel = '0;
        chk("R7 ack after release", 32'(have_reset), 32'h0);

        // R8: halt-group request
        hg_halt_req = 4'b1010; #1;
        chk("R8 halt_irq from group", 32'(halt_irq), 32'ha);
        tick();
        hg_halt_req = '0;

        // R9: inactive clears
        halted_wr = 1'b1; halted_id = 4'd1; go_start = 1'b1; hart_in_reset = 4'b0100; tick();
        halted_wr = 1'b0; go_start = 1'b0; ticks(4);
        dm_active = 1'b0; tick();
        chk("R9 halted cleared", 32'(halted), 32'h0);
        chk("R9 flags cleared", 32'(flags), 32'h0);
        chk("R9 have_reset cleared", 32'(have_reset), 32'h0);
        hart_in_reset = '0; dm_active = 1'b1; tick();

        // Free overlap of all inputs, compared by the model each cycle.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            halted_wr      = (r[1:0] == 2'd0);
            halted_id      = {1'b0, r[4:2]};
            resuming_wr    = (r[6:5] == 2'd0);
            resuming_id    = {1'b0, r[9:7]};
            going_wr       = (r[12:10] == 3'd0);
            go_start       = (r[15:13] == 3'd0);
            resume_req     = (r[17:16] == 2'd0);
            hart_sel       = r[21:18];
            sel_hart       = r[23:22];
            set_hr         = (r[26:24] == 3'd0);
            clr_hr         = (r[29:27] == 3'd0);
            ack_have_reset = (r[31:30] == 2'd0);
            r = $urandom;
            if (r[3:0] == 4'd0) hart_in_reset = r[7:4];
            hg_halt_req = (r[10:8] == 3'd0) ? r[14:11] : 4'b0;
            dm_active   = (r[20:15] != 6'd0);
            tick();
        end

        summary();
        $finish;
    end

endmodule